// File: doc/BRIEF.md
# Column Drain Arbiter with Removal Priority

This block picks which crosspoint buffer drains next in one output column of an N-port buffered crossbar. On every clock, which is one slot, it looks at two vectors. The first shows which crosspoint buffers in its column hold a cell. The second shows which inputs are asking the output to take their cell now. From these it grants at most one buffer to the output link.

The block has two selection modes. If any input asks for removal and the buffer it names holds a cell, the grant goes to one of those asking buffers. Otherwise the block serves the occupied buffers in plain rotation. Both modes search from one shared priority pointer. After each grant the pointer moves to the position just past the served input.

One slot after each grant, a notification pulse carries the served input's index back to the input side. The input side uses it to release the credit it holds for that buffer. The cell datapath and the buffers themselves lie outside this block.

Top module: `xbar_col_drain_arb`

## Requirements
- R1: After reset the priority pointer sits at input 0 and no notification is raised. With every buffer occupied and no removal asked, the first grant goes to input 0.
- R2: A grant (`grant_vld` high) names only a buffer whose bit in `cell_present` is 1. When `cell_present` is all zero, `grant_vld` stays low. At most one index is granted per slot.
- R3: When at least one input has both its `remove_req` bit and its `cell_present` bit set, the grant goes to the first such input found when searching upward from the pointer and wrapping from N-1 to 0.
- R4: A `remove_req` bit whose buffer is empty has no effect. The grant is then the same as it would be with that bit clear.
- R5: When no removal request is live, the grant goes to the first occupied buffer found when searching upward from the pointer with wrap-around.
- R6: After a grant to input k, the pointer becomes k+1, or 0 when k is N-1. The pointer does not change in a slot without a grant. The same pointer serves both selection modes.
- R7: In the slot after a grant to input k, `notify_vld` is high for exactly that one slot and `notify_idx` equals k. `notify_vld` is low in the slot after a slot with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_present | input | N | Bit i set: crosspoint buffer of input i holds a cell |
| remove_req | input | N | Bit i set: input i asks for removal of its cell |
| grant_vld | output | 1 | A buffer is drained this slot |
| grant_idx | output | $clog2(N) | Index of the drained buffer |
| notify_vld | output | 1 | Delivery notification, one slot after the grant |
| notify_idx | output | $clog2(N) | Input that receives the notification |

## Verification
Two functions can meet in the same slot. The notification for the previous slot's grant goes out while a new grant is chosen from a pointer that the previous grant has just moved. The second case is a removal request that names an empty buffer while other buffers are occupied, so the removal mode and the rotation mode are both in play. The bench provokes both with runs of back-to-back occupied slots and with random removal bits over sparse occupancy. A behavioural model, kept as plain integers, predicts the grant and the pending notification for every slot. Each slot's outputs are compared with that model.

// File: rtl/xbar_col_drain_arb.sv
module xbar_col_drain_arb #(
  parameter int N = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N-1:0]                         cell_present,
  input  logic [N-1:0]                         remove_req,
  output logic                                 grant_vld,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] grant_idx,
  output logic                                 notify_vld,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] notify_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [N-1:0]  live_rm;
  logic [N-1:0]  cand;
  logic          hit;
  logic [IW-1:0] pick;

  assign live_rm = cell_present & remove_req;
  assign cand    = (|live_rm) ? live_rm : cell_present;

  always_comb begin
    int j;
    hit  = 1'b0;
    pick = '0;
    for (int k = 0; k < N; k++) begin
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!hit && cand[j]) begin
        hit  = 1'b1;
        pick = IW'(j);
      end
    end
  end

  assign grant_vld = hit;
  assign grant_idx = pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      notify_vld <= 1'b0;
      notify_idx <= '0;
    end else begin
      notify_vld <= hit;
      if (hit) begin
        notify_idx <= pick;
        ptr        <= (int'(pick) == N - 1) ? '0 : pick + 1'b1;
      end
    end
  end

  a_r2_grant_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> cell_present[grant_idx]);
  a_r2_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    (|cell_present) == grant_vld);
  a_r3_removal_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cell_present & remove_req)) |-> remove_req[grant_idx]);
  a_r7_notify_follows: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |=> (notify_vld && notify_idx == $past(grant_idx)));
  a_r7_notify_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |=> !notify_vld);
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |=> $stable(ptr));
endmodule

// File: tb/xbar_col_drain_arb_tb.sv
module xbar_col_drain_arb_tb_top;
  localparam int N       = 5;
  localparam int IW      = $clog2(N);
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cell_present = '0;
  logic [N-1:0] remove_req = '0;
  logic grant_vld, notify_vld;
  logic [IW-1:0] grant_idx, notify_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_ptr = 0;
  int m_prev_vld = 0;
  int m_prev_idx = 0;

  always #(CLK_PER/2) clk = ~clk;

  xbar_col_drain_arb #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cell_present(cell_present), .remove_req(remove_req),
    .grant_vld(grant_vld), .grant_idx(grant_idx),
    .notify_vld(notify_vld), .notify_idx(notify_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic slot(input logic [N-1:0] occ, input logic [N-1:0] rm);
    int ev, ei, live, pos;
    string tag;
    @(negedge clk);
    cell_present = occ;
    remove_req = rm;
    #1;
    live = 0;
    for (int i = 0; i < N; i++) if (occ[i] && rm[i]) live = 1;
    ev = 0; ei = 0; pos = m_ptr;
    repeat (N) begin
      if (ev == 0 && occ[pos] && (live == 0 || rm[pos])) begin ev = 1; ei = pos; end
      pos = (pos + 1) % N;
    end
    if (live != 0) tag = "R3";
    else if (rm != '0) tag = "R4";
    else tag = "R5";
    chk(grant_vld == ev, "R2 grant_vld", grant_vld, ev);
    if (ev != 0) chk(int'(grant_idx) == ei, tag, grant_idx, ei);
    chk(notify_vld == m_prev_vld, "R7 notify_vld", notify_vld, m_prev_vld);
    if (m_prev_vld != 0) chk(int'(notify_idx) == m_prev_idx, "R7 notify_idx", notify_idx, m_prev_idx);
    m_prev_vld = ev;
    m_prev_idx = ei;
    if (ev != 0) m_ptr = (ei + 1) % N;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(notify_vld == 1'b0, "R1 notify in reset", notify_vld, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first grant from pointer 0
    slot('1, '0);
    // R5 and R6: rotation of the pointer across all inputs
    repeat (N + 2) slot('1, '0);
    // R2: nothing occupied, pointer must hold (R6)
    slot('0, '1);
    slot('0, '0);
    // R4: removal bits on empty buffers only
    slot(5'b00101, 5'b11010);
    slot(5'b00101, 5'b11010);
    // R3: removal beats rotation, shared pointer (R6)
    slot(5'b11111, 5'b01000);
    slot(5'b11111, 5'b00001);
    slot(5'b10110, 5'b10010);
    slot(5'b10110, 5'b10010);
    // N-1 wrap for R6
    slot(5'b10000, '0);
    slot(5'b00011, '0);
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] o, r;
      o = N'($urandom);
      r = N'($urandom) & N'($urandom);
      if ((n % 7) == 0) o = '0;
      slot(o, r);
    end
    slot('0, '0);
    slot('0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule